// File: doc/BRIEF.md
# Cache block flush controller

This block carries out a flush-block command against a small direct-mapped write-back data cache whose tag, state and data arrays sit outside it. A 32-bit instruction word is presented with a valid strobe. When it decodes as a flush, the block reads two register operands through a combinational register-read port and adds them to form the effective address. It then looks up the selected cache line through a combinational cache port. A line that is present and modified is written back to main memory one word at a time over a request/acknowledge port, and is then invalidated. A line that is present and clean is only invalidated. A line that is absent causes no traffic and no invalidation.

A separate synchronize strobe asks the block to confirm that no flush write-back is still waiting for main memory. The block handles one command at a time and holds `busy` high while it works. Commands that arrive while it is busy are dropped, so the issuing side must wait for `busy` to fall before it presents the next command.

The cache is 16 lines of 16 bytes with 32-bit addresses. Bits [3:0] of the address are the byte offset, bits [7:4] the line index and bits [31:8] the tag.

Top module: `blk_flush_unit`

## Requirements
- R1: A word is accepted as a flush only when `cmd_insn[31:26]` equals 31 and `cmd_insn[10:1]` equals 86. Bits [25:21] and bit [0] may hold any value. Any other word presented with `cmd_valid` is dropped: `busy` stays low and no line changes.
- R2: The base register number is `cmd_insn[20:16]` and the index register number is `cmd_insn[15:11]`. The effective address is base plus index. A base field of 0 contributes the value zero instead of register 0. An index field of 0 still reads register 0.
- R3: The line is selected by address bits [7:4]. A hit requires the line's valid flag and a tag equal to address bits [31:8]. The offset bits [3:0] play no part, and an invalid line with a matching tag counts as a miss.
- R4: On a miss, `flush_done` pulses in the second cycle after acceptance. There is no memory request, no invalidation, and the cache line keeps its state.
- R5: On a modified hit, four writes are issued for words 0 to 3 in order. Each write has `mem_addr` = {address bits [31:4], word, 2'b00} and `mem_wdata` = that cached word. `mem_req`, the address and the data are held until `mem_ack`, and one word is retired per acknowledge.
- R6: On any hit, `ch_inval` is high for exactly one cycle with `ch_index` equal to the line. This comes after the last write-back, or directly after the lookup when the line is clean. `flush_done` pulses in the following cycle.
- R7: `busy` is high from the cycle after a command is accepted up to, and not including, the cycle in which its done pulse appears.
- R8: A flush or synchronize command presented while `busy` is high is dropped. It starts no later work and changes no line.
- R9: A synchronize accepted while idle gives `sync_done` in the second cycle after acceptance, with `busy` high in between. `sync_done` is never high while a write-back request is outstanding.
- R10: When a valid flush and a synchronize arrive in the same idle cycle, the flush is carried out and the synchronize is dropped.
- R11: After reset, `busy`, `flush_done`, `sync_done`, `mem_req` and `ch_inval` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Instruction word strobe |
| cmd_insn | input | 32 | Instruction word |
| sync_valid | input | 1 | Synchronize command strobe |
| busy | output | 1 | Command in progress |
| flush_done | output | 1 | One-cycle flush completion pulse |
| sync_done | output | 1 | One-cycle synchronize completion pulse |
| rf_addr_a | output | 5 | Base register number |
| rf_addr_b | output | 5 | Index register number |
| rf_data_a | input | 32 | Base register contents |
| rf_data_b | input | 32 | Index register contents |
| ch_index | output | 4 | Cache line being examined |
| ch_word | output | 2 | Word select for cache data read |
| ch_valid | input | 1 | Valid flag of selected line |
| ch_dirty | input | 1 | Modified flag of selected line |
| ch_tag | input | 24 | Tag of selected line |
| ch_rdata | input | 32 | Selected cache word |
| ch_inval | output | 1 | Clear valid and modified flags of line `ch_index` |
| mem_req | output | 1 | Write-back request |
| mem_addr | output | 32 | Write-back word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory accepted current word |

## Verification
The hardest case to reach is a command that arrives while a slow write-back is in progress. Reaching it needs a modified hit, an acknowledge held off for several cycles, and a competing flush and synchronize presented during the lookup cycle. The bench builds this by filling a second line as modified, then stretching the acknowledge latency of the first flush. It presents the intruding commands in the cycle right after acceptance. Afterwards it confirms that the intruder's line is still valid, that exactly four memory beats occurred, and that no stray done pulse follows.

// File: rtl/blk_flush_pkg.sv
package blk_flush_pkg;
    localparam logic [5:0] PRIMARY_OP = 6'd31;
    localparam logic [9:0] EXT_OP     = 10'd86;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_INVALIDATE,
        ST_SYNC
    } flush_state_e;
endpackage

// File: rtl/blk_flush_decode.sv
module blk_flush_decode
    import blk_flush_pkg::*;
(
    input  logic [31:0] insn,
    output logic        is_flush,
    output logic [4:0]  base_reg,
    output logic [4:0]  index_reg
);
    logic [5:0] unused_resv;

    assign is_flush    = (insn[31:26] == PRIMARY_OP) && (insn[10:1] == EXT_OP);
    assign base_reg    = insn[20:16];
    assign index_reg   = insn[15:11];
    assign unused_resv = {insn[25:21], insn[0]};
endmodule

// File: rtl/blk_flush_agen.sv
module blk_flush_agen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [4:0]        base_reg,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    output logic [IDX_W-1:0]  line_idx,
    output logic [TAG_W-1:0]  line_tag
);
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] sum;
    logic [OFF_W-1:0]  unused_off;

    assign base_term  = (base_reg == 5'd0) ? '0 : base_val;
    assign sum        = base_term + index_val;
    assign line_idx   = sum[OFF_W +: IDX_W];
    assign line_tag   = sum[ADDR_W-1 -: TAG_W];
    assign unused_off = sum[OFF_W-1:0];
endmodule

// File: rtl/blk_flush_fsm.sv
module blk_flush_fsm
    import blk_flush_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 4,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WCNT_W = OFF_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_ok,
    input  logic [4:0]        cmd_base,
    input  logic [4:0]        cmd_index,
    input  logic              sync_valid,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic              ch_valid,
    input  logic              ch_dirty,
    input  logic [TAG_W-1:0]  ch_tag,
    input  logic [31:0]       ch_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              flush_done,
    output logic              sync_done,
    output logic [4:0]        rf_addr_a,
    output logic [4:0]        rf_addr_b,
    output logic [IDX_W-1:0]  ch_index,
    output logic [WCNT_W-1:0] ch_word,
    output logic              ch_inval,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    localparam logic [WCNT_W-1:0] LAST_WORD = '1;

    typedef struct packed {
        flush_state_e      state;
        logic [4:0]        base;
        logic [4:0]        index;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [WCNT_W-1:0] wcnt;
        logic              fdone;
        logic              sdone;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  hit;

    assign hit = ch_valid && (ch_tag == look_tag);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fdone = 1'b0;
        ctl_d.sdone = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_ok) begin
                    ctl_d.state = ST_LOOKUP;
                    ctl_d.base  = cmd_base;
                    ctl_d.index = cmd_index;
                end else if (sync_valid) begin
                    ctl_d.state = ST_SYNC;
                end
            end
            ST_LOOKUP: begin
                ctl_d.idx  = look_idx;
                ctl_d.tag  = look_tag;
                ctl_d.wcnt = '0;
                if (!hit) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.fdone = 1'b1;
                end else if (ch_dirty) begin
                    ctl_d.state = ST_WRITEBACK;
                end else begin
                    ctl_d.state = ST_INVALIDATE;
                end
            end
            ST_WRITEBACK: begin
                if (mem_ack) begin
                    if (ctl_q.wcnt == LAST_WORD) begin
                        ctl_d.state = ST_INVALIDATE;
                    end else begin
                        ctl_d.wcnt = ctl_q.wcnt + 1'b1;
                    end
                end
            end
            ST_INVALIDATE: begin
                ctl_d.state = ST_IDLE;
                ctl_d.fdone = 1'b1;
            end
            ST_SYNC: begin
                ctl_d.state = ST_IDLE;
                ctl_d.sdone = 1'b1;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.state != ST_IDLE);
    assign flush_done = ctl_q.fdone;
    assign sync_done  = ctl_q.sdone;
    assign rf_addr_a  = ctl_q.base;
    assign rf_addr_b  = ctl_q.index;
    assign ch_index   = (ctl_q.state == ST_LOOKUP) ? look_idx : ctl_q.idx;
    assign ch_word    = ctl_q.wcnt;
    assign ch_inval   = (ctl_q.state == ST_INVALIDATE);
    assign mem_req    = (ctl_q.state == ST_WRITEBACK);
    assign mem_addr   = {ctl_q.tag, ctl_q.idx, ctl_q.wcnt, 2'b00};
    assign mem_wdata  = ch_rdata;

    // R5: request and address hold steady until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5: each acknowledge below the last word moves to the next word
    p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && ch_word != LAST_WORD) |=>
        (mem_req && ch_word == WCNT_W'($past(ch_word) + 1'b1)));

    // R6: invalidation is a single cycle, followed by the done pulse
    p_inval_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_inval |=> (!ch_inval && flush_done));

    // R6: no write-back runs during invalidation
    p_inval_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_inval && mem_req));

    // R7: completion pulses only when no longer busy
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_done || sync_done) |-> !busy);

    // R9: synchronize never completes with a write-back outstanding
    p_sync_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> !mem_req);
endmodule

// File: rtl/blk_flush_unit.sv
module blk_flush_unit #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 4,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int WCNT_W = OFF_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [31:0]       cmd_insn,
    input  logic              sync_valid,
    output logic              busy,
    output logic              flush_done,
    output logic              sync_done,
    output logic [4:0]        rf_addr_a,
    output logic [4:0]        rf_addr_b,
    input  logic [ADDR_W-1:0] rf_data_a,
    input  logic [ADDR_W-1:0] rf_data_b,
    output logic [IDX_W-1:0]  ch_index,
    output logic [WCNT_W-1:0] ch_word,
    input  logic              ch_valid,
    input  logic              ch_dirty,
    input  logic [TAG_W-1:0]  ch_tag,
    input  logic [31:0]       ch_rdata,
    output logic              ch_inval,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack
);
    logic             is_flush;
    logic [4:0]       dec_base;
    logic [4:0]       dec_index;
    logic [IDX_W-1:0] look_idx;
    logic [TAG_W-1:0] look_tag;

    blk_flush_decode u_decode (
        .insn      (cmd_insn),
        .is_flush  (is_flush),
        .base_reg  (dec_base),
        .index_reg (dec_index)
    );

    blk_flush_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_agen (
        .base_reg  (rf_addr_a),
        .base_val  (rf_data_a),
        .index_val (rf_data_b),
        .line_idx  (look_idx),
        .line_tag  (look_tag)
    );

    blk_flush_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_ok     (cmd_valid && is_flush),
        .cmd_base   (dec_base),
        .cmd_index  (dec_index),
        .sync_valid (sync_valid),
        .look_idx   (look_idx),
        .look_tag   (look_tag),
        .ch_valid   (ch_valid),
        .ch_dirty   (ch_dirty),
        .ch_tag     (ch_tag),
        .ch_rdata   (ch_rdata),
        .mem_ack    (mem_ack),
        .busy       (busy),
        .flush_done (flush_done),
        .sync_done  (sync_done),
        .rf_addr_a  (rf_addr_a),
        .rf_addr_b  (rf_addr_b),
        .ch_index   (ch_index),
        .ch_word    (ch_word),
        .ch_inval   (ch_inval),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: tb/blk_flush_unit_bench.sv
module blk_flush_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, sync_valid, mem_ack;
    logic [31:0] cmd_insn;
    logic        busy, flush_done, sync_done, ch_inval, mem_req;
    logic [4:0]  rf_addr_a, rf_addr_b;
    logic [31:0] rf_data_a, rf_data_b, ch_rdata, mem_addr, mem_wdata;
    logic [3:0]  ch_index;
    logic [1:0]  ch_word;
    logic        ch_valid, ch_dirty;
    logic [23:0] ch_tag;

    logic [31:0] rf [32];
    logic        cv [16];
    logic        cd [16];
    logic [23:0] ctag [16];
    logic [31:0] cdat [16][4];
    int          beats = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    bit          intrude = 0;
    logic [31:0] intr_insn;

    always #5 clk = ~clk;

    blk_flush_unit u_blk_flush_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_insn(cmd_insn),
        .sync_valid(sync_valid), .busy(busy), .flush_done(flush_done),
        .sync_done(sync_done), .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b), .ch_index(ch_index),
        .ch_word(ch_word), .ch_valid(ch_valid), .ch_dirty(ch_dirty),
        .ch_tag(ch_tag), .ch_rdata(ch_rdata), .ch_inval(ch_inval),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack)
    );

    assign rf_data_a = rf[rf_addr_a];
    assign rf_data_b = rf[rf_addr_b];
    assign ch_valid  = cv[ch_index];
    assign ch_dirty  = cd[ch_index];
    assign ch_tag    = ctag[ch_index];
    assign ch_rdata  = cdat[ch_index][ch_word];

    always @(posedge clk) begin
        if (rst_n && ch_inval) begin
            cv[ch_index] <= 1'b0;
            cd[ch_index] <= 1'b0;
        end
        if (rst_n && mem_req && mem_ack) beats <= beats + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [9:0] xo, input bit resv);
        return {op, resv ? 5'h1f : 5'h00, ra, rb, xo, resv};
    endfunction

    task automatic fill(input int i, input logic [23:0] t, input bit v, input bit d);
        cv[i] = v; cd[i] = d; ctag[i] = t;
        for (int w = 0; w < 4; w++) cdat[i][w] = 32'hA500_0000 ^ (i << 12) ^ (w << 4) ^ {8'h0, t};
    endtask

    task automatic flush(input logic [31:0] insn, input int lat, input bit with_sync);
        logic [31:0] ea;
        logic [3:0]  idx;
        bit          hit, dirty, before_v;
        int          b0;
        ea = ((insn[20:16] == 5'd0) ? 32'd0 : rf[insn[20:16]]) + rf[insn[15:11]];
        idx = ea[7:4];
        hit = cv[idx] && (ctag[idx] == ea[31:8]);
        dirty = hit && cd[idx];
        before_v = cv[idx];
        b0 = beats;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_insn = insn; sync_valid = with_sync;
        @(negedge clk);
        cmd_valid = 1'b0; sync_valid = 1'b0;
        chk("R7", "busy in lookup", busy, 1);
        chk("R4", "no req in lookup", mem_req, 0);
        chk("R6", "no inval in lookup", ch_inval, 0);
        if (intrude) begin
            cmd_valid = 1'b1; cmd_insn = intr_insn; sync_valid = 1'b1;
        end
        @(negedge clk);
        cmd_valid = 1'b0; sync_valid = 1'b0;
        if (!hit) begin
            chk("R4", "miss done", flush_done, 1);
            chk("R7", "miss busy low", busy, 0);
            chk("R4", "miss no inval", ch_inval, 0);
            chk("R4", "miss beats", beats, b0);
            chk("R4", "miss line kept", cv[idx], before_v);
        end else begin
            if (dirty) begin
                for (int w = 0; w < 4; w++) begin
                    for (int k = 0; k <= lat; k++) begin
                        chk("R5", "req held", mem_req, 1);
                        chk("R5", "wb addr", mem_addr, {ea[31:4], w[1:0], 2'b00});
                        chk("R5", "wb data", mem_wdata, cdat[idx][w]);
                        chk("R7", "busy in wb", busy, 1);
                        if (k == lat) mem_ack = 1'b1;
                        @(negedge clk);
                        mem_ack = 1'b0;
                    end
                end
            end
            chk("R6", "inval strobe", ch_inval, 1);
            chk("R6", "inval index", ch_index, idx);
            chk("R6", "no req at inval", mem_req, 0);
            @(negedge clk);
            chk("R6", "hit done", flush_done, 1);
            chk("R7", "hit busy low", busy, 0);
            chk("R6", "line invalid", cv[idx], 0);
            chk("R5", "beat count", beats, b0 + (dirty ? 4 : 0));
        end
        @(negedge clk);
        chk("R8", "idle after done", busy, 0);
        chk("R10", "no stray sync done", sync_done, 0);
        chk("R8", "no stray flush done", flush_done, 0);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; sync_valid = 1'b0; mem_ack = 1'b0; cmd_insn = '0;
        intr_insn = '0;
        for (int r = 0; r < 32; r++) rf[r] = 32'h0100_0000 * r;
        for (int i = 0; i < 16; i++) fill(i, 24'hFFFFFF, 0, 0);
        repeat (3) @(negedge clk);
        chk("R11", "busy", busy, 0);
        chk("R11", "flush_done", flush_done, 0);
        chk("R11", "sync_done", sync_done, 0);
        chk("R11", "mem_req", mem_req, 0);
        chk("R11", "ch_inval", ch_inval, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "busy after release", busy, 0);

        rf[0] = 32'h0000_0010; rf[3] = 32'h0000_0040; rf[4] = 32'h0000_4500;
        rf[6] = 32'h1234_5678; rf[7] = 32'h0000_0004; rf[8] = 32'hBBBB_BB90;
        rf[10] = 32'h0000_ABC0;

        // R5: modified hit, immediate acknowledge
        fill(4, 24'h000045, 1, 1);
        flush(mk(6'd31, 5'd4, 5'd3, 10'd86, 0), 0, 0);

        // R3: clean hit with nonzero offset bits
        fill(7, 24'h123456, 1, 0);
        flush(mk(6'd31, 5'd6, 5'd7, 10'd86, 0), 0, 0);

        // R4 / R2: base field 0 reads zero; tag mismatch is a miss
        fill(9, 24'hAAAAAA, 1, 1);
        flush(mk(6'd31, 5'd0, 5'd8, 10'd86, 0), 0, 0);
        chk("R4", "mismatched line still dirty", cd[9], 1);

        // R2: base field 0 reaching a modified hit, latency 1
        fill(9, 24'hBBBBBB, 1, 1);
        flush(mk(6'd31, 5'd0, 5'd8, 10'd86, 0), 1, 0);

        // R1 / R8: reserved bits set, slow ack, intruding flush and sync
        fill(13, 24'h0000AB, 1, 1);
        fill(4, 24'h000045, 1, 1);
        intr_insn = mk(6'd31, 5'd4, 5'd3, 10'd86, 0);
        intrude = 1;
        flush(mk(6'd31, 5'd10, 5'd0, 10'd86, 1), 3, 0);
        intrude = 0;
        chk("R8", "intruder line untouched", cv[4], 1);

        // R10: flush and sync together
        fill(2, 24'h000000, 0, 0);
        flush(mk(6'd31, 5'd0, 5'd0, 10'd86, 0), 0, 1);

        // R3: invalid line with matching tag is a miss
        fill(4, 24'h000045, 0, 1);
        flush(mk(6'd31, 5'd4, 5'd3, 10'd86, 0), 0, 0);

        // R1: wrong primary or extended field is dropped
        fill(4, 24'h000045, 1, 1);
        @(negedge clk); cmd_valid = 1'b1; cmd_insn = mk(6'd30, 5'd4, 5'd3, 10'd86, 0);
        @(negedge clk); cmd_insn = mk(6'd31, 5'd4, 5'd3, 10'd87, 0);
        chk("R1", "bad opcode not busy", busy, 0);
        @(negedge clk); cmd_valid = 1'b0;
        chk("R1", "bad ext not busy", busy, 0);
        @(negedge clk);
        chk("R1", "no done", flush_done, 0);
        chk("R1", "line kept", cv[4], 1);

        // R9: standalone synchronize
        @(negedge clk); sync_valid = 1'b1;
        @(negedge clk); sync_valid = 1'b0;
        chk("R9", "busy during sync", busy, 1);
        chk("R9", "not yet done", sync_done, 0);
        @(negedge clk);
        chk("R9", "sync done", sync_done, 1);
        chk("R9", "busy low", busy, 0);
        chk("R9", "no req", mem_req, 0);
        @(negedge clk);
        chk("R9", "pulse ends", sync_done, 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule